// File: doc/BRIEF.md
# Ethernet MAC Transmit-Clock Control Block

This block sits next to a gigabit Ethernet MAC and owns the small set of clock-related controls the MAC depends on. Software reaches it through an APB slave port. It stores per-clock enables, two delay-line settings (receive and transmit), a choice of gigabit transmit-clock source, the PHY interface mode, and the direction of the transmit-clock pin. These settings leave the block as static control levels. The block also contains an integer divider that derives the transmit clock from the reference clock. For 1000, 100 and 10 Mb/s the targets are 125 MHz, 25 MHz and 2.5 MHz, and software picks a divisor that divides the reference exactly.

The divider output appears in the reference-clock domain as two signals. The first is a level `div_clk` with a duty cycle as near 50% as an integer count allows. The second is a one-cycle `div_tick` at the start of each period. The block runs entirely on the reference clock, which also clocks the APB port. Any write to the divider word restarts the count from the beginning of a high phase, so a new divisor never produces a shortened pulse. The usual sequence is to write zero and then write the divisor with the enable bit set.

Top module: `eth_clkglue_top`

## Requirements
- R1: After reset every register reads 0, every control output is 0, and `div_clk`/`div_tick` are low.
- R2: Offset 0x00 holds six clock enables: bit1 TX clock, bit2 inverted TX clock, bit3 TX clock output, bit4 RX clock, bit5 inverted RX clock, bit6 external PHY reference clock. Each bit drives its own output. All other bits read 0.
- R3: Offsets 0x04 (receive) and 0x08 (transmit) each hold a delay tap in bits [4:0], an invert bit at bit14 and a bypass bit at bit15. These drive the matching outputs, and all other bits read 0.
- R4: Offset 0x0C holds the divisor in bits [7:0] and the divider enable at bit31. While bit31 is 0, `div_clk` and `div_tick` stay low.
- R5: With the divider enabled and divisor d ≥ 2, `div_clk` repeats every d cycles. It is high for the first ceil(d/2) cycles of each period, and `div_tick` is high only in the first cycle of each period.
- R6: With the divider enabled and divisor 0 or 1, `div_clk` and `div_tick` are high every cycle.
- R7: Any write to offset 0x0C restarts the divider. If the written enable is 1, the cycle after the write edge is the first cycle of a full-length high phase, even when the write lands mid-period.
- R8: Bit0 of offset 0x18 drives `gtx_sel_pll` (1 selects the divider output). Bit0 of 0x1C drives `intf_rgmii` (1 means RGMII, 0 means MII/GMII). Bit0 of 0x20 drives `txclk_pin_input` (0 drives the pin out, 1 takes it as an input).
- R9: Writes to unmapped offsets change no register and no output. Reads of unmapped offsets return 0. `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the APB clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 6 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| tx_clk_en | output | 1 | TX clock enable |
| tx_clk_inv_en | output | 1 | Inverted TX clock enable |
| tx_clk_out_en | output | 1 | TX clock output enable |
| rx_clk_en | output | 1 | RX clock enable |
| rx_clk_inv_en | output | 1 | Inverted RX clock enable |
| phy_ref_clk_en | output | 1 | External PHY reference clock enable |
| rx_dly_tap | output | 5 | Receive delay tap |
| rx_dly_inv | output | 1 | Receive clock invert |
| rx_dly_bypass | output | 1 | Receive delay bypass |
| tx_dly_tap | output | 5 | Transmit delay tap |
| tx_dly_inv | output | 1 | Transmit clock invert |
| tx_dly_bypass | output | 1 | Transmit delay bypass |
| gtx_sel_pll | output | 1 | Gigabit transmit clock taken from the divider |
| intf_rgmii | output | 1 | Interface mode, 1 for RGMII |
| txclk_pin_input | output | 1 | TX clock pin direction, 1 for input |
| div_clk | output | 1 | Divided clock level |
| div_tick | output | 1 | One-cycle pulse at the start of each divided period |

## Verification
The hardest situation to reach from the ports is a divider rewrite that lands partway through a running high or low phase. Only in that case can a runt pulse or a stale count appear. The bench starts the divider and waits a chosen number of cycles so that the next write's access phase falls inside a high phase, and later inside a low phase. It then compares every following cycle with the pattern that should start on the cycle after the write edge. Around that targeted case, the bench sweeps every divisor from 0 to 255 through the disable-then-enable sequence and checks each cycle of two full periods arithmetically.

// File: rtl/eth_clkglue_pkg.sv
package eth_clkglue_pkg;
  localparam int PADDR_W = 6;
  localparam int PDATA_W = 32;

  localparam logic [PADDR_W-1:0] OFS_CKEN  = 6'h00;
  localparam logic [PADDR_W-1:0] OFS_RXDLY = 6'h04;
  localparam logic [PADDR_W-1:0] OFS_TXDLY = 6'h08;
  localparam logic [PADDR_W-1:0] OFS_DIV   = 6'h0C;
  localparam logic [PADDR_W-1:0] OFS_GTX   = 6'h18;
  localparam logic [PADDR_W-1:0] OFS_INTF  = 6'h1C;
  localparam logic [PADDR_W-1:0] OFS_TXDIR = 6'h20;

  localparam int CKEN_LSB  = 1;
  localparam int CKEN_W    = 6;
  localparam int DLY_INV   = 14;
  localparam int DLY_BYP   = 15;
  localparam int DIV_EN    = 31;
  localparam int NUM_DLY   = 2;
endpackage

// File: rtl/eth_clkglue_rstsync.sv
module eth_clkglue_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/eth_clkglue_regs.sv
module eth_clkglue_regs
  import eth_clkglue_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TAP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [PDATA_W-1:0] pwdata,
  output logic [PDATA_W-1:0] prdata,
  output logic [CKEN_W-1:0]  cken,
  output logic [TAP_W-1:0]   dly_tap [NUM_DLY],
  output logic               dly_inv [NUM_DLY],
  output logic               dly_byp [NUM_DLY],
  output logic               div_en,
  output logic [DIV_W-1:0]   div_val,
  output logic               gtx_sel,
  output logic               intf_sel,
  output logic               txdir_sel,
  output logic               div_load,
  output logic               div_load_en,
  output logic [DIV_W-1:0]   div_load_val
);
  logic wr_stb;
  logic hit;

  logic [CKEN_W-1:0] cken_q, cken_d;
  logic              div_en_q, div_en_d;
  logic [DIV_W-1:0]  div_val_q, div_val_d;
  logic              gtx_q, gtx_d;
  logic              intf_q, intf_d;
  logic              txdir_q, txdir_d;
  logic [PDATA_W-1:0] dly_word [NUM_DLY];

  assign wr_stb = psel && penable && pwrite;

  always_comb begin
    case (paddr)
      OFS_CKEN, OFS_RXDLY, OFS_TXDLY, OFS_DIV,
      OFS_GTX, OFS_INTF, OFS_TXDIR: hit = 1'b1;
      default:                      hit = 1'b0;
    endcase
  end

  // single-field registers: next state
  always_comb begin
    cken_d    = cken_q;
    div_en_d  = div_en_q;
    div_val_d = div_val_q;
    gtx_d     = gtx_q;
    intf_d    = intf_q;
    txdir_d   = txdir_q;
    if (wr_stb) begin
      case (paddr)
        OFS_CKEN:  cken_d = pwdata[CKEN_LSB +: CKEN_W];
        OFS_DIV: begin
          div_en_d  = pwdata[DIV_EN];
          div_val_d = pwdata[DIV_W-1:0];
        end
        OFS_GTX:   gtx_d   = pwdata[0];
        OFS_INTF:  intf_d  = pwdata[0];
        OFS_TXDIR: txdir_d = pwdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cken_q    <= '0;
      div_en_q  <= 1'b0;
      div_val_q <= '0;
      gtx_q     <= 1'b0;
      intf_q    <= 1'b0;
      txdir_q   <= 1'b0;
    end else begin
      cken_q    <= cken_d;
      div_en_q  <= div_en_d;
      div_val_q <= div_val_d;
      gtx_q     <= gtx_d;
      intf_q    <= intf_d;
      txdir_q   <= txdir_d;
    end
  end

  // delay-line channels: 0 = receive, 1 = transmit
  for (genvar ch = 0; ch < NUM_DLY; ch++) begin : g_dly
    localparam logic [PADDR_W-1:0] CH_OFS = (ch == 0) ? OFS_RXDLY : OFS_TXDLY;
    logic [TAP_W-1:0] tap_q, tap_d;
    logic             inv_q, inv_d;
    logic             byp_q, byp_d;
    logic             ch_wr;

    assign ch_wr = wr_stb && (paddr == CH_OFS);

    always_comb begin
      tap_d = tap_q;
      inv_d = inv_q;
      byp_d = byp_q;
      if (ch_wr) begin
        tap_d = pwdata[TAP_W-1:0];
        inv_d = pwdata[DLY_INV];
        byp_d = pwdata[DLY_BYP];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tap_q <= '0;
        inv_q <= 1'b0;
        byp_q <= 1'b0;
      end else begin
        tap_q <= tap_d;
        inv_q <= inv_d;
        byp_q <= byp_d;
      end
    end

    always_comb begin
      dly_word[ch]             = '0;
      dly_word[ch][TAP_W-1:0]  = tap_q;
      dly_word[ch][DLY_INV]    = inv_q;
      dly_word[ch][DLY_BYP]    = byp_q;
    end

    assign dly_tap[ch] = tap_q;
    assign dly_inv[ch] = inv_q;
    assign dly_byp[ch] = byp_q;
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      OFS_CKEN:  prdata[CKEN_LSB +: CKEN_W] = cken_q;
      OFS_RXDLY: prdata = dly_word[0];
      OFS_TXDLY: prdata = dly_word[1];
      OFS_DIV: begin
        prdata[DIV_W-1:0] = div_val_q;
        prdata[DIV_EN]    = div_en_q;
      end
      OFS_GTX:   prdata[0] = gtx_q;
      OFS_INTF:  prdata[0] = intf_q;
      OFS_TXDIR: prdata[0] = txdir_q;
      default: ;
    endcase
  end

  assign cken         = cken_q;
  assign div_en       = div_en_q;
  assign div_val      = div_val_q;
  assign gtx_sel      = gtx_q;
  assign intf_sel     = intf_q;
  assign txdir_sel    = txdir_q;
  assign div_load     = wr_stb && (paddr == OFS_DIV);
  assign div_load_en  = pwdata[DIV_EN];
  assign div_load_val = pwdata[DIV_W-1:0];

  logic [PDATA_W*2+CKEN_W+DIV_W+3:0] state_vec;
  assign state_vec = {dly_word[0], dly_word[1], cken_q, div_en_q, div_val_q,
                      gtx_q, intf_q, txdir_q};

  // R9
  unmapped_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !hit) |=> $stable(state_vec));
endmodule

// File: rtl/eth_clkglue_div.sv
module eth_clkglue_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_en,
  input  logic [DIV_W-1:0] load_val,
  output logic             div_clk,
  output logic             div_tick
);
  logic             run_q, run_d;
  logic [DIV_W-1:0] val_q, val_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] last;
  logic [DIV_W:0]   hi_len;

  assign eff    = (val_q < DIV_W'(2)) ? DIV_W'(1) : val_q;
  assign last   = eff - DIV_W'(1);
  assign hi_len = ({1'b0, eff} + (DIV_W+1)'(1)) >> 1;

  always_comb begin
    run_d = run_q;
    val_d = val_q;
    cnt_d = cnt_q;
    if (load) begin
      run_d = load_en;
      val_d = load_val;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = (cnt_q == last) ? '0 : cnt_q + DIV_W'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      val_q <= '0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      val_q <= val_d;
      cnt_q <= cnt_d;
    end
  end

  assign div_clk  = run_q && ({1'b0, cnt_q} < hi_len);
  assign div_tick = run_q && (cnt_q == '0);

  // R5
  tick_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |-> div_clk);
endmodule

// File: rtl/eth_clkglue_top.sv
module eth_clkglue_top
  import eth_clkglue_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TAP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [PDATA_W-1:0] pwdata,
  output logic [PDATA_W-1:0] prdata,
  output logic               pready,
  output logic               pslverr,
  output logic               tx_clk_en,
  output logic               tx_clk_inv_en,
  output logic               tx_clk_out_en,
  output logic               rx_clk_en,
  output logic               rx_clk_inv_en,
  output logic               phy_ref_clk_en,
  output logic [TAP_W-1:0]   rx_dly_tap,
  output logic               rx_dly_inv,
  output logic               rx_dly_bypass,
  output logic [TAP_W-1:0]   tx_dly_tap,
  output logic               tx_dly_inv,
  output logic               tx_dly_bypass,
  output logic               gtx_sel_pll,
  output logic               intf_rgmii,
  output logic               txclk_pin_input,
  output logic               div_clk,
  output logic               div_tick
);
  logic              rst_sync_n;
  logic [CKEN_W-1:0] cken;
  logic [TAP_W-1:0]  dly_tap [NUM_DLY];
  logic              dly_inv [NUM_DLY];
  logic              dly_byp [NUM_DLY];
  logic              div_en;
  logic [DIV_W-1:0]  div_val;
  logic              div_load, div_load_en;
  logic [DIV_W-1:0]  div_load_val;

  eth_clkglue_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eth_clkglue_regs #(.DIV_W(DIV_W), .TAP_W(TAP_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .psel         (psel),
    .penable      (penable),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .prdata       (prdata),
    .cken         (cken),
    .dly_tap      (dly_tap),
    .dly_inv      (dly_inv),
    .dly_byp      (dly_byp),
    .div_en       (div_en),
    .div_val      (div_val),
    .gtx_sel      (gtx_sel_pll),
    .intf_sel     (intf_rgmii),
    .txdir_sel    (txclk_pin_input),
    .div_load     (div_load),
    .div_load_en  (div_load_en),
    .div_load_val (div_load_val)
  );

  eth_clkglue_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (div_load),
    .load_en  (div_load_en),
    .load_val (div_load_val),
    .div_clk  (div_clk),
    .div_tick (div_tick)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign tx_clk_en      = cken[0];
  assign tx_clk_inv_en  = cken[1];
  assign tx_clk_out_en  = cken[2];
  assign rx_clk_en      = cken[3];
  assign rx_clk_inv_en  = cken[4];
  assign phy_ref_clk_en = cken[5];

  assign rx_dly_tap    = dly_tap[0];
  assign rx_dly_inv    = dly_inv[0];
  assign rx_dly_bypass = dly_byp[0];
  assign tx_dly_tap    = dly_tap[1];
  assign tx_dly_inv    = dly_inv[1];
  assign tx_dly_bypass = dly_byp[1];

  // high-phase length monitor for the runt check
  logic [DIV_W-1:0] chk_eff;
  logic [DIV_W:0]   chk_hi_exp;
  logic [DIV_W:0]   hi_run_q;

  assign chk_eff    = (div_val < DIV_W'(2)) ? DIV_W'(1) : div_val;
  assign chk_hi_exp = ({1'b0, chk_eff} + (DIV_W+1)'(1)) >> 1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   hi_run_q <= '0;
    else if (div_load) hi_run_q <= '0;
    else if (div_clk)  hi_run_q <= hi_run_q + (DIV_W+1)'(1);
    else               hi_run_q <= '0;
  end

  // R4
  idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !div_en |-> (!div_clk && !div_tick));

  // R7
  no_runt_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!div_load && !div_clk && (hi_run_q != '0)) |-> (hi_run_q == chk_hi_exp));
endmodule

// File: tb/eth_clkglue_top_tb.sv
module eth_clkglue_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [5:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic        tx_clk_en, tx_clk_inv_en, tx_clk_out_en;
  logic        rx_clk_en, rx_clk_inv_en, phy_ref_clk_en;
  logic [4:0]  rx_dly_tap, tx_dly_tap;
  logic        rx_dly_inv, rx_dly_bypass, tx_dly_inv, tx_dly_bypass;
  logic        gtx_sel_pll, intf_rgmii, txclk_pin_input;
  logic        div_clk, div_tick;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  eth_clkglue_top u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tx_clk_en(tx_clk_en), .tx_clk_inv_en(tx_clk_inv_en),
    .tx_clk_out_en(tx_clk_out_en), .rx_clk_en(rx_clk_en),
    .rx_clk_inv_en(rx_clk_inv_en), .phy_ref_clk_en(phy_ref_clk_en),
    .rx_dly_tap(rx_dly_tap), .rx_dly_inv(rx_dly_inv),
    .rx_dly_bypass(rx_dly_bypass), .tx_dly_tap(tx_dly_tap),
    .tx_dly_inv(tx_dly_inv), .tx_dly_bypass(tx_dly_bypass),
    .gtx_sel_pll(gtx_sel_pll), .intf_rgmii(intf_rgmii),
    .txclk_pin_input(txclk_pin_input), .div_clk(div_clk), .div_tick(div_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // compare two periods of the divider against the arithmetic pattern;
  // called on the negedge right after the write edge
  task automatic check_pattern(input int d, input string tag);
    int eff = (d < 2) ? 1 : d;
    int hi  = (eff + 1) / 2;
    int errs = 0;
    int first_k = -1;
    bit exp_c, exp_t;
    for (int k = 0; k < 2*eff + 2; k++) begin
      exp_c = ((k % eff) < hi);
      exp_t = ((k % eff) == 0);
      if (div_clk !== exp_c || div_tick !== exp_t) begin
        if (errs == 0) first_k = k;
        errs++;
      end
      @(negedge clk);
    end
    check(errs == 0, $sformatf("%s div=%0d first bad cycle=%0d", tag, d, first_k),
          errs, 0);
  endtask

  initial begin
    logic [31:0] rd;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i <= 8; i++) begin
      apb_rd(6'(i*4), rd);
      check(rd == 0, $sformatf("R1 reset read ofs=0x%0h", i*4), rd, 0);
    end
    check({tx_clk_en, tx_clk_inv_en, tx_clk_out_en, rx_clk_en, rx_clk_inv_en,
           phy_ref_clk_en, gtx_sel_pll, intf_rgmii, txclk_pin_input,
           div_clk, div_tick} == 0, "R1 reset outputs", 1, 0);

    // R2 clock enables, one bit at a time then all
    for (int b = 1; b <= 6; b++) begin
      apb_wr(6'h00, 32'(1) << b);
      apb_rd(6'h00, rd);
      check(rd == (32'(1) << b), "R2 readback single", rd, 32'(1) << b);
      check({phy_ref_clk_en, rx_clk_inv_en, rx_clk_en, tx_clk_out_en,
             tx_clk_inv_en, tx_clk_en} == 6'(1 << (b-1)), "R2 outputs single",
            {phy_ref_clk_en, rx_clk_inv_en, rx_clk_en, tx_clk_out_en,
             tx_clk_inv_en, tx_clk_en}, 1 << (b-1));
    end
    apb_wr(6'h00, 32'hFFFF_FFFF);
    apb_rd(6'h00, rd);
    check(rd == 32'h7E, "R2 readback mask", rd, 32'h7E);

    // R3 delay registers
    apb_wr(6'h04, 32'hFFFF_FFFF);
    apb_rd(6'h04, rd);
    check(rd == 32'h0000_C01F, "R3 rx mask", rd, 32'h0000_C01F);
    apb_wr(6'h04, 32'h0000_4015);
    apb_wr(6'h08, 32'h0000_800A);
    check(rx_dly_tap == 5'h15 && rx_dly_inv && !rx_dly_bypass, "R3 rx outputs",
          {rx_dly_bypass, rx_dly_inv, rx_dly_tap}, {1'b0, 1'b1, 5'h15});
    check(tx_dly_tap == 5'h0A && !tx_dly_inv && tx_dly_bypass, "R3 tx outputs",
          {tx_dly_bypass, tx_dly_inv, tx_dly_tap}, {1'b1, 1'b0, 5'h0A});
    apb_rd(6'h08, rd);
    check(rd == 32'h0000_800A, "R3 tx readback", rd, 32'h0000_800A);

    // R8 single-bit selects
    apb_wr(6'h18, 32'hFFFF_FFFF);
    apb_wr(6'h1C, 32'h1);
    apb_wr(6'h20, 32'h0);
    check(gtx_sel_pll && intf_rgmii && !txclk_pin_input, "R8 rgmii set",
          {gtx_sel_pll, intf_rgmii, txclk_pin_input}, 3'b110);
    apb_rd(6'h18, rd);
    check(rd == 32'h1, "R8 gtx readback", rd, 1);
    apb_wr(6'h1C, 32'h0);
    apb_wr(6'h20, 32'h1);
    check(!intf_rgmii && txclk_pin_input, "R8 mii set",
          {intf_rgmii, txclk_pin_input}, 2'b01);

    // R9 unmapped writes ignored, reads zero, no error
    for (int a = 0; a < 64; a += 4) begin
      if (a == 6'h10 || a == 6'h14 || a > 6'h20) begin
        apb_wr(6'(a), 32'hFFFF_FFFF);
        apb_rd(6'(a), rd);
        check(rd == 0 && pslverr == 0 && pready == 1,
              $sformatf("R9 unmapped ofs=0x%0h", a), rd, 0);
      end
    end
    apb_rd(6'h00, rd);
    check(rd == 32'h7E, "R9 cken untouched", rd, 32'h7E);
    apb_rd(6'h04, rd);
    check(rd == 32'h4015, "R9 rx delay untouched", rd, 32'h4015);
    apb_rd(6'h0C, rd);
    check(rd == 0 && !div_clk, "R9 divider untouched", rd, 0);

    // R4 divisor loaded but disabled stays idle
    apb_wr(6'h0C, 32'h0000_0005);
    begin
      int hits = 0;
      for (int k = 0; k < 20; k++) begin
        if (div_clk || div_tick) hits++;
        @(negedge clk);
      end
      check(hits == 0, "R4 disabled idle", hits, 0);
    end
    apb_rd(6'h0C, rd);
    check(rd == 32'h5, "R4 readback", rd, 5);

    // R5 / R6 full divisor sweep with disable-then-enable sequence
    for (int d = 0; d < 256; d++) begin
      apb_wr(6'h0C, 32'h0);
      apb_wr(6'h0C, 32'h8000_0000 | 32'(d));
      check_pattern(d, (d < 2) ? "R6 passthrough" : "R5 divide");
    end

    // R7 rewrite landing in a high phase
    apb_wr(6'h0C, 32'h8000_000C);
    @(negedge clk);
    apb_wr(6'h0C, 32'h8000_0004);
    check_pattern(4, "R7 rewrite mid-high");
    // R7 rewrite landing in a low phase (pattern of 4 ends on a low cycle)
    repeat (2) @(negedge clk);
    apb_wr(6'h0C, 32'h8000_0009);
    check_pattern(9, "R7 rewrite mid-low");
    // R7 disable mid-period, then re-enable
    apb_wr(6'h0C, 32'h0);
    check(!div_clk && !div_tick, "R7 disable stops", div_clk, 0);
    apb_wr(6'h0C, 32'h8000_0007);
    check_pattern(7, "R7 re-enable");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule